// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Node

This block is one node of a shared-bus arbitration chain. A single central arbiter raises one grant line, and that line passes from node to node, with each node feeding the next. A node whose device wants the bus raises a request. When the grant reaches a node that is requesting, the node keeps the grant, answers with a selection acknowledge, and later becomes the bus owner. A node that is not requesting passes the grant on to its downstream neighbour.

Ownership begins when the arbiter has withdrawn the grant and the previous owner has released the busy line. At that point the node drives busy and signals its local transaction engine to start. Ownership ends once both handshake strobes, master sync and slave sync, are low after master sync has been seen.

A node that is passing the grant on keeps doing so until the grant input itself falls. It does not release early on a downstream acknowledge. Releasing early would let a node that re-requests at once mistake the stale grant for its own grant. The grant, busy and handshake inputs are asynchronous, so each one passes through a multi-flop synchronizer before it reaches the state logic.

Top module: `arb_node`

## Requirements
- R1: While reset is asserted, and in the idle state after reset, the outputs req_o, grant_out_o, sel_ack_o, busy_o and owner_o are all low.
- R2: An idle node whose need_i is high when a clock edge arrives raises req_o from that edge. The need input is a local signal and is not synchronized.
- R3: A requesting node that sees the synchronized grant raises sel_ack_o and drops req_o. The grant is then not passed downstream.
- R4: An idle node with need_i low that sees the synchronized grant raises grant_out_o.
- R5: A forwarding node keeps grant_out_o high for as long as the synchronized grant is high, even when its need_i rises meanwhile. It never raises sel_ack_o on that same grant, so at most one node in a chain shows sel_ack_o at any time.
- R6: A node holds sel_ack_o until the synchronized grant and the synchronized busy input are both low. It then drops sel_ack_o and raises busy_o and owner_o together.
- R7: Ownership continues while either synchronized strobe is high, and it continues without limit before master sync has first been seen. It ends once both strobes are low after master sync has been seen.
- R8: The grant, busy, msyn and ssyn inputs each pass through SYNC_STAGES flops. With the default of 2, a change on grant_in_i becomes visible on grant_out_o at the third rising edge after the change.
- R9: In a chain, the requesting node nearest the arbiter takes the grant first. Each node that needs the bus is served exactly once per need.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| need_i | input | 1 | Local device wants the bus |
| grant_in_i | input | 1 | Grant from the upstream node or from the arbiter (asynchronous) |
| busy_in_i | input | 1 | Shared bus-busy line (asynchronous) |
| msyn_i | input | 1 | Master sync strobe (asynchronous) |
| ssyn_i | input | 1 | Slave sync strobe (asynchronous) |
| req_o | output | 1 | Bus request to the arbiter |
| grant_out_o | output | 1 | Grant passed to the downstream node |
| sel_ack_o | output | 1 | Selection acknowledge |
| busy_o | output | 1 | Drives the shared busy line while owning |
| owner_o | output | 1 | Start and ownership indication for the transaction engine |

## Verification
The bench chains three nodes behind a behavioural arbiter and a handshake model. It sweeps every combination of the initial set of needs against every set of nodes that raise need at the moment the first acknowledge appears. The initial set shows whether priority goes to the node nearest the arbiter. The late set puts forwarding nodes under the stale-grant race, and a second acknowledge in any cycle exposes a node that released early. Directed phases then hold the foreign busy line, step the two strobes one at a time, and measure the grant latency through the synchronizer. These phases separate the acknowledge-hold condition, the transaction-end condition and the synchronizer depth from one another.

// File: rtl/arb_node_pkg.sv
package arb_node_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_FWD  = 3'd2,
    ST_ACK  = 3'd3,
    ST_OWN  = 3'd4,
    ST_XFER = 3'd5
  } arb_state_e;

  // Bit positions of the asynchronous inputs inside the synchronizer bundle
  localparam int unsigned IX_GRANT = 0;
  localparam int unsigned IX_BUSY  = 1;
  localparam int unsigned IX_MSYN  = 2;
  localparam int unsigned IX_SSYN  = 3;
  localparam int unsigned N_ASYNC  = 4;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  // Assertion is immediate, release walks a one through the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_node_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic need_i,
  input  logic grant_s,
  input  logic busy_s,
  input  logic msyn_s,
  input  logic ssyn_s,
  output logic req_o,
  output logic grant_out_o,
  output logic sel_ack_o,
  output logic busy_o,
  output logic owner_o
);

  arb_state_e state_q;
  arb_state_e state_d;
  logic       state_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        // Local need wins over a passing grant: a grant seen together with
        // need is taken, not forwarded
        if (need_i) begin
          state_d = ST_REQ;
        end else if (grant_s) begin
          state_d = ST_FWD;
        end
      end
      ST_REQ: begin
        if (grant_s) begin
          state_d = ST_ACK;
        end
      end
      ST_FWD: begin
        // Leave only on the grant falling; a downstream acknowledge is not
        // enough, or a stale grant could be claimed
        if (!grant_s) begin
          state_d = ST_IDLE;
        end
      end
      ST_ACK: begin
        if (!grant_s && !busy_s) begin
          state_d = ST_OWN;
        end
      end
      ST_OWN: begin
        if (msyn_s) begin
          state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        if (!msyn_s && !ssyn_s) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // Moore outputs
  always_comb begin
    req_o       = (state_q == ST_REQ);
    grant_out_o = (state_q == ST_FWD);
    sel_ack_o   = (state_q == ST_ACK);
    owner_o     = (state_q == ST_OWN) || (state_q == ST_XFER);
    busy_o      = owner_o;
  end

endmodule

// File: rtl/arb_node.sv
module arb_node
  import arb_node_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_i,
  input  logic grant_in_i,
  input  logic busy_in_i,
  input  logic msyn_i,
  input  logic ssyn_i,
  output logic req_o,
  output logic grant_out_o,
  output logic sel_ack_o,
  output logic busy_o,
  output logic owner_o
);

  logic               rst_n_int;
  logic [N_ASYNC-1:0] async_raw;
  logic [N_ASYNC-1:0] async_sync;
  logic               grant_s;
  logic               busy_s;
  logic               msyn_s;
  logic               ssyn_s;

  arb_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    async_raw           = '0;
    async_raw[IX_GRANT] = grant_in_i;
    async_raw[IX_BUSY]  = busy_in_i;
    async_raw[IX_MSYN]  = msyn_i;
    async_raw[IX_SSYN]  = ssyn_i;
  end

  arb_sync #(
    .WIDTH  (N_ASYNC),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (async_raw),
    .q_o   (async_sync)
  );

  assign grant_s = async_sync[IX_GRANT];
  assign busy_s  = async_sync[IX_BUSY];
  assign msyn_s  = async_sync[IX_MSYN];
  assign ssyn_s  = async_sync[IX_SSYN];

  arb_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .need_i      (need_i),
    .grant_s     (grant_s),
    .busy_s      (busy_s),
    .msyn_s      (msyn_s),
    .ssyn_s      (ssyn_s),
    .req_o       (req_o),
    .grant_out_o (grant_out_o),
    .sel_ack_o   (sel_ack_o),
    .busy_o      (busy_o),
    .owner_o     (owner_o)
  );

endmodule

// File: rtl/arb_node_chk.sv
module arb_node_chk (
  input logic clk,
  input logic rst_n,
  input logic need_i,
  input logic req_o,
  input logic grant_out_o,
  input logic sel_ack_o,
  input logic owner_o,
  input logic grant_s,
  input logic busy_s,
  input logic msyn_s,
  input logic ssyn_s
);

  // R2: a request only starts when need was present at the edge before
  a_r2_req_from_need: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(need_i));

  // R3: a requester that sees the grant acknowledges on the next edge
  a_r3_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && grant_s) |=> sel_ack_o);

  // R4: an idle node without need passes a seen grant on
  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (!need_i && grant_s && !req_o && !sel_ack_o && !owner_o && !grant_out_o)
      |=> grant_out_o);

  // R5: forwarding persists while the grant is still seen
  a_r5_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_out_o && grant_s) |=> (grant_out_o && !sel_ack_o));

  // R6: acknowledge is held while grant or busy is still seen
  a_r6_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ack_o && (grant_s || busy_s)) |=> sel_ack_o);

  // R6: acknowledge only ends by handing over to ownership
  a_r6_ack_to_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_ack_o) |-> owner_o);

  // R7: ownership is kept while any strobe is seen high
  a_r7_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_o && (msyn_s || ssyn_s)) |=> owner_o);

endmodule

bind arb_node arb_node_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .need_i      (need_i),
  .req_o       (req_o),
  .grant_out_o (grant_out_o),
  .sel_ack_o   (sel_ack_o),
  .owner_o     (owner_o),
  .grant_s     (grant_s),
  .busy_s      (busy_s),
  .msyn_s      (msyn_s),
  .ssyn_s      (ssyn_s)
);

// File: tb/arb_node_tb.sv
module arb_node_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NODES      = 3;

  logic clk;
  logic rst_n;
  logic [NODES-1:0] need;
  logic bg;
  logic foreign_busy;
  logic msyn;
  logic ssyn;
  logic [NODES-1:0] req;
  logic [NODES-1:0] gout;
  logic [NODES-1:0] sack;
  logic [NODES-1:0] busyo;
  logic [NODES-1:0] own;
  logic [NODES:0]   chain;
  logic             bbsy;

  int vectors;
  int fails;
  bit done;

  bit auto_arb;
  bit auto_hs;
  bit armed;
  bit late_armed;
  logic [NODES-1:0] late_mask;
  int served [NODES];
  int first_w;
  int sack_ovl;
  int own_ovl;
  int hs_ph;
  bit arb_st;

  assign chain[0] = bg;
  assign bbsy = (|busyo) | foreign_busy;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    assign chain[i+1] = gout[i];
    arb_node u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .need_i      (need[i]),
      .grant_in_i  (chain[i]),
      .busy_in_i   (bbsy),
      .msyn_i      (msyn),
      .ssyn_i      (ssyn),
      .req_o       (req[i]),
      .grant_out_o (gout[i]),
      .sel_ack_o   (sack[i]),
      .busy_o      (busyo[i]),
      .owner_o     (own[i])
    );
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Arbiter model: grant on any request, withdraw on any acknowledge
  initial begin
    arb_st = 1'b0;
    forever begin
      @(negedge clk);
      if (auto_arb) begin
        if (!arb_st) begin
          if ((|req) && !(|sack)) begin
            bg = 1'b1;
            arb_st = 1'b1;
          end
        end else if (|sack) begin
          bg = 1'b0;
          arb_st = 1'b0;
        end
      end
    end
  end

  // Handshake model for the owning node
  initial begin
    hs_ph = 0;
    forever begin
      @(negedge clk);
      if (auto_hs) begin
        case (hs_ph)
          0: if (|own) begin msyn = 1'b1; hs_ph = 1; end
          1: begin ssyn = 1'b1; hs_ph = 2; end
          2: begin msyn = 1'b0; hs_ph = 3; end
          3: begin ssyn = 1'b0; hs_ph = 4; end
          default: if (!(|own)) hs_ph = 0;
        endcase
      end
    end
  end

  // Monitor: ownership starts, overlaps, late-need injection
  initial begin
    logic [NODES-1:0] prev_own;
    prev_own = '0;
    forever begin
      @(negedge clk);
      if (armed) begin
        for (int i = 0; i < NODES; i++) begin
          if (own[i] && !prev_own[i]) begin
            served[i]++;
            if (first_w < 0) first_w = i;
            need[i] = 1'b0;
          end
        end
        if ($countones(sack) > 1) sack_ovl++;
        if ($countones(own) > 1) own_ovl++;
        if (late_armed && (|sack)) begin
          need = need | late_mask;
          late_armed = 1'b0;
        end
      end
      prev_own = own;
    end
  end

  task automatic clear_stats();
    for (int i = 0; i < NODES; i++) served[i] = 0;
    first_w  = -1;
    sack_ovl = 0;
    own_ovl  = 0;
  endtask

  function automatic int lowest(input logic [NODES-1:0] m);
    for (int i = 0; i < NODES; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    vectors = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; need = '0; bg = 1'b0; foreign_busy = 1'b0;
    msyn = 1'b0; ssyn = 1'b0;
    auto_arb = 1'b0; auto_hs = 1'b0; armed = 1'b0; late_armed = 1'b0;
    late_mask = '0;
    clear_stats();

    // R1: reset state
    cyc(4);
    for (int i = 0; i < NODES; i++)
      check({req[i], gout[i], sack[i], busyo[i], own[i]} == 5'b0, "R1 reset",
            {req[i], gout[i], sack[i], busyo[i], own[i]}, 0);
    rst_n = 1'b1;
    cyc(6);
    for (int i = 0; i < NODES; i++)
      check({req[i], gout[i], sack[i], busyo[i], own[i]} == 5'b0, "R1 idle",
            {req[i], gout[i], sack[i], busyo[i], own[i]}, 0);

    // R2: request one edge after need
    need[2] = 1'b1;
    cyc(1);
    check(req[2] == 1'b1, "R2 request", req[2], 1);

    // R8: grant latency through the synchronizer
    bg = 1'b1;
    cyc(2);
    check(gout[0] == 1'b0, "R8 early", gout[0], 0);
    cyc(1);
    check(gout[0] == 1'b1, "R8 arrive", gout[0], 1);

    // R4 and R3: grant flows past nodes 0,1 and is claimed by node 2
    cyc(10);
    check(gout[0] && gout[1], "R4 forward", {gout[1], gout[0]}, 3);
    check(sack[2] && !req[2] && !gout[2], "R3 claim",
          {sack[2], req[2], gout[2]}, 4);

    // R5: forwarders raise need while the grant is still up
    need = 3'b011;
    cyc(20);
    check(gout[0] && gout[1], "R5 hold forward", {gout[1], gout[0]}, 3);
    check($countones(sack) == 1, "R5 single ack", $countones(sack), 1);

    // R6: acknowledge held while a foreign owner keeps busy
    foreign_busy = 1'b1;
    bg = 1'b0;
    cyc(14);
    check(sack[2] && !own[2], "R6 wait busy", {sack[2], own[2]}, 2);
    check(req[0] && req[1] && !sack[0] && !sack[1], "R5 no false claim",
          {sack[1], sack[0], req[1], req[0]}, 3);
    foreign_busy = 1'b0;
    cyc(2);
    check(!own[2], "R6 busy latency", own[2], 0);
    cyc(1);
    check(own[2] && busyo[2] && !sack[2], "R6 take bus",
          {own[2], busyo[2], sack[2]}, 6);

    // R7: ownership end needs both strobes low after msyn
    cyc(10);
    check(own[2], "R7 before msyn", own[2], 1);
    msyn = 1'b1; cyc(4);
    ssyn = 1'b1; cyc(4);
    msyn = 1'b0; cyc(6);
    check(own[2], "R7 ssyn holds", own[2], 1);
    ssyn = 1'b0; cyc(2);
    check(own[2], "R7 sync delay", own[2], 1);
    cyc(1);
    check(!own[2] && !busyo[2], "R7 release", {own[2], busyo[2]}, 0);

    // R9: pending requests of nodes 0 and 1 served in priority order
    clear_stats();
    armed = 1'b1; auto_arb = 1'b1; auto_hs = 1'b1;
    for (int t = 0; t < 600; t++) begin
      cyc(1);
      if (need == '0 && !(|own) && !(|sack) && hs_ph == 0) break;
    end
    cyc(10);
    check(first_w == 0, "R9 priority", first_w, 0);
    check(served[0] == 1 && served[1] == 1 && served[2] == 0, "R9 served once",
          served[0] + 2*served[1] + 4*served[2], 3);

    // Sweep: initial need set x late-need set
    for (int ini = 0; ini < 8; ini++) begin
      for (int lat = 0; lat < 8; lat++) begin
        int exp_tot;
        int tot;
        logic [NODES-1:0] all;
        clear_stats();
        all = (ini == 0) ? 3'b000 : 3'(ini | lat);
        exp_tot = $countones(all);
        late_mask = 3'(lat);
        late_armed = 1'b1;
        need = 3'(ini);
        for (int t = 0; t < 800; t++) begin
          cyc(1);
          tot = served[0] + served[1] + served[2];
          if (tot == exp_tot && !(|req) && !(|sack) && !(|own) && !bg &&
              hs_ph == 0 && !bbsy) break;
        end
        late_armed = 1'b0;
        cyc(20);
        tot = served[0] + served[1] + served[2];
        check(tot == exp_tot, "R9 count", tot, exp_tot);
        for (int i = 0; i < NODES; i++)
          check(served[i] == int'(all[i]), "R9 per node", served[i], int'(all[i]));
        check(first_w == lowest(3'(ini)), "R9 first winner", first_w,
              lowest(3'(ini)));
        check(sack_ovl == 0, "R5 double ack", sack_ovl, 0);
        check(own_ovl == 0, "R6 double owner", own_ovl, 0);
      end
    end

    // R1: everything back to idle
    for (int i = 0; i < NODES; i++)
      check({req[i], gout[i], sack[i], busyo[i], own[i]} == 5'b0, "R1 final idle",
            {req[i], gout[i], sack[i], busyo[i], own[i]}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule